// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between the address bus of an 8-bit processor and its memory and peripheral devices. It holds a 4-bit bank number that picks one of sixteen 64 KB banks, and it turns every CPU address into at most one active-low chip select. The selectable devices are two RAM devices, one ROM, a serial controller, a user parallel interface and a system parallel interface, plus the bank register itself. It also drives the three upper address lines of the selected RAM device, so that together the two RAM devices hold all sixteen banks.

The bank number only matters in some windows. The lowest 4 KB always reach bank 0 of RAM device A. The general RAM window always follows the bank number. The window from A000 to DFFF holds ROM while bank 0 is active and RAM otherwise. The top 8 KB is always ROM. The I/O pages in the 9xxx range ignore the bank. Software changes the bank by writing a nibble anywhere in page 9Fxx.

The decode is built in two stages. The first stage sorts the high address byte into one of nine regions (`RG_FIXED_LOW`, `RG_BANKED`, `RG_SWAP`, `RG_ROM`, `RG_SERIAL`, `RG_PIO_USER`, `RG_PIO_SYS`, `RG_BANK_REG`, `RG_HOLE`). The second stage turns the region and the bank number into the selects. The bank register is the only stored state. Reset sets it to 0. Its only transition is a load, taken on a clock edge when the write strobe is high inside `RG_BANK_REG`. Every other cycle holds the value.

Top module: `bankmap_decode_top`

## Requirements
- R1: After reset the bank register holds 0, so address 1000 selects RAM device A with `ram_hi` = 000.
- R2: A clock edge with `wr_stb` high and an address in 9F00..9FFF loads `data_lo` into the bank register. The new bank is used from the next cycle on.
- R3: The bank register keeps its value when page 9Fxx is accessed with `wr_stb` low, and when `wr_stb` is high at any address outside 9F00..9FFF.
- R4: Addresses 0000..0FFF select RAM device A with `ram_hi` = 000 for every bank value.
- R5: Addresses 1000..8FFF select RAM device A for banks 0..7 and RAM device B for banks 8..15. `ram_hi` equals bank bits 2..0.
- R6: Addresses A000..DFFF select the ROM when the bank is 0. For any other bank they select RAM exactly as in R5.
- R7: Addresses E000..FFFF select the ROM for every bank value.
- R8: Page 91xx selects the serial controller, 92xx the user parallel interface and 93xx the system parallel interface, for every bank value.
- R9: Page 9Fxx asserts `bank_sel_n` for every bank value, whether the access is a read or a write.
- R10: Addresses 9000..90FF and 9400..9EFF assert no select.
- R11: At most one of the seven selects is low at any time. `ram_hi` is 000 whenever neither RAM select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| wr_stb | input | 1 | Write strobe, active high |
| data_lo | input | 4 | Low nibble of the CPU data bus |
| ram_a_n | output | 1 | RAM device A select, active low |
| ram_b_n | output | 1 | RAM device B select, active low |
| rom_n | output | 1 | ROM select, active low |
| ser_n | output | 1 | Serial controller select, active low |
| pio_usr_n | output | 1 | User parallel interface select, active low |
| pio_sys_n | output | 1 | System parallel interface select, active low |
| bank_sel_n | output | 1 | Bank register select, active low |
| ram_hi | output | 3 | Upper RAM address lines A18..A16 |

## Verification
The bank register cannot be read back, so its contents can only be observed through the decode. The hardest case is proving that a load did not happen. After a read of page 9Fxx, or a strobed write to a hole or an I/O page, the stimulus probes the banked window and checks that `ram_hi` and the device select still show the earlier bank. The swap window only shows its dual behaviour as the bank changes. For that reason the stimulus loads all sixteen bank values in turn and probes both the general RAM window and the swap window after each load. That covers the bank-0 ROM case, the RAM-A/RAM-B split at bank 8, and the upper address lines for every bank.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

    // Region classes produced by the first decode stage
    typedef enum logic [3:0] {
        RG_FIXED_LOW = 4'd0,
        RG_BANKED    = 4'd1,
        RG_SWAP      = 4'd2,
        RG_ROM       = 4'd3,
        RG_SERIAL    = 4'd4,
        RG_PIO_USER  = 4'd5,
        RG_PIO_SYS   = 4'd6,
        RG_BANK_REG  = 4'd7,
        RG_HOLE      = 4'd8
    } region_e;

    // Active-high internal select set
    typedef struct packed {
        logic ram_a;
        logic ram_b;
        logic rom;
        logic serial;
        logic pio_user;
        logic pio_sys;
        logic bank_reg;
    } sel_t;

    // Fixed 4 KB block numbers (top nibble of the address)
    localparam logic [3:0] BLK_FIXED     = 4'h0;
    localparam logic [3:0] BLK_RAM_FIRST = 4'h1;
    localparam logic [3:0] BLK_RAM_LAST  = 4'h8;
    localparam logic [3:0] BLK_IO        = 4'h9;
    localparam logic [3:0] BLK_SWP_FIRST = 4'hA;
    localparam logic [3:0] BLK_SWP_LAST  = 4'hD;

    // Page numbers inside the I/O block (second nibble)
    localparam logic [3:0] PG_SERIAL   = 4'h1;
    localparam logic [3:0] PG_PIO_USER = 4'h2;
    localparam logic [3:0] PG_PIO_SYS  = 4'h3;
    localparam logic [3:0] PG_BANK_REG = 4'hF;

endpackage

// File: rtl/bankmap_region.sv
module bankmap_region
    import bankmap_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] page,
    output region_e           region
);
    localparam int NIB_W = 4;

    logic [NIB_W-1:0] blk;
    logic [NIB_W-1:0] sub;

    assign blk = page[PAGE_W-1 -: NIB_W];
    assign sub = page[PAGE_W-NIB_W-1 -: NIB_W];

    always_comb begin
        region = RG_HOLE;
        if (blk == BLK_FIXED) begin
            region = RG_FIXED_LOW;
        end else if (blk >= BLK_RAM_FIRST && blk <= BLK_RAM_LAST) begin
            region = RG_BANKED;
        end else if (blk == BLK_IO) begin
            unique case (sub)
                PG_SERIAL:   region = RG_SERIAL;
                PG_PIO_USER: region = RG_PIO_USER;
                PG_PIO_SYS:  region = RG_PIO_SYS;
                PG_BANK_REG: region = RG_BANK_REG;
                default:     region = RG_HOLE;
            endcase
        end else if (blk >= BLK_SWP_FIRST && blk <= BLK_SWP_LAST) begin
            region = RG_SWAP;
        end else begin
            region = RG_ROM;
        end
    end

endmodule

// File: rtl/bankmap_bankreg.sv
module bankmap_bankreg #(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              hit,
    input  logic [BANK_W-1:0] din,
    output logic [BANK_W-1:0] bank
);
    logic              load;
    logic [BANK_W-1:0] bank_nx;

    assign load = wr_stb & hit;

    always_comb begin
        bank_nx = bank;
        if (load) begin
            bank_nx = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank <= '0;
        end else begin
            bank <= bank_nx;
        end
    end

    // R2
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && hit) |=> (bank == $past(din)));

    // R3
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && hit) |=> $stable(bank));

endmodule

// File: rtl/bankmap_select.sv
module bankmap_select
    import bankmap_pkg::*;
#(
    parameter int BANK_W = 4
) (
    input  region_e           region,
    input  logic [BANK_W-1:0] bank,
    output sel_t              sel,
    output logic [BANK_W-2:0] ram_hi
);
    localparam int HI_W = BANK_W - 1;

    logic              upper_dev;
    logic              bank_zero;
    logic [HI_W-1:0]   bank_low;

    assign upper_dev = bank[BANK_W-1];
    assign bank_zero = (bank == '0);
    assign bank_low  = bank[HI_W-1:0];

    always_comb begin
        sel    = '0;
        ram_hi = '0;
        unique case (region)
            RG_FIXED_LOW: begin
                sel.ram_a = 1'b1;
            end
            RG_BANKED: begin
                sel.ram_a = ~upper_dev;
                sel.ram_b = upper_dev;
                ram_hi    = bank_low;
            end
            RG_SWAP: begin
                if (bank_zero) begin
                    sel.rom = 1'b1;
                end else begin
                    sel.ram_a = ~upper_dev;
                    sel.ram_b = upper_dev;
                    ram_hi    = bank_low;
                end
            end
            RG_ROM:      sel.rom      = 1'b1;
            RG_SERIAL:   sel.serial   = 1'b1;
            RG_PIO_USER: sel.pio_user = 1'b1;
            RG_PIO_SYS:  sel.pio_sys  = 1'b1;
            RG_BANK_REG: sel.bank_reg = 1'b1;
            default: begin
                sel    = '0;
                ram_hi = '0;
            end
        endcase
    end

endmodule

// File: rtl/bankmap_decode_top.sv
module bankmap_decode_top
    import bankmap_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              wr_stb,
    input  logic [BANK_W-1:0] data_lo,
    output logic              ram_a_n,
    output logic              ram_b_n,
    output logic              rom_n,
    output logic              ser_n,
    output logic              pio_usr_n,
    output logic              pio_sys_n,
    output logic              bank_sel_n,
    output logic [BANK_W-2:0] ram_hi
);
    localparam int HI_W = BANK_W - 1;

    region_e           region;
    logic [BANK_W-1:0] bank;
    sel_t              sel;
    logic [HI_W-1:0]   hi_int;
    logic [6:0]        sel_n_vec;

    bankmap_region #(.PAGE_W(PAGE_W)) u_region (
        .page   (cpu_addr[ADDR_W-1 -: PAGE_W]),
        .region (region)
    );

    bankmap_bankreg #(.BANK_W(BANK_W)) u_bankreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .hit    (region == RG_BANK_REG),
        .din    (data_lo),
        .bank   (bank)
    );

    bankmap_select #(.BANK_W(BANK_W)) u_select (
        .region (region),
        .bank   (bank),
        .sel    (sel),
        .ram_hi (hi_int)
    );

    assign ram_a_n    = ~sel.ram_a;
    assign ram_b_n    = ~sel.ram_b;
    assign rom_n      = ~sel.rom;
    assign ser_n      = ~sel.serial;
    assign pio_usr_n  = ~sel.pio_user;
    assign pio_sys_n  = ~sel.pio_sys;
    assign bank_sel_n = ~sel.bank_reg;
    assign ram_hi     = hi_int;

    assign sel_n_vec = {ram_a_n, ram_b_n, rom_n, ser_n, pio_usr_n, pio_sys_n, bank_sel_n};

    // R11
    one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n_vec));

    // R11
    hi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_a_n && ram_b_n) |-> (ram_hi == '0));

    // R4
    low_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < 16'h1000) |-> (!ram_a_n && ram_hi == '0));

    // R7
    top_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= 16'hE000) |-> !rom_n);

    // R8
    serial_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[ADDR_W-1 -: PAGE_W] == 8'h91) |-> !ser_n);

    // R9
    bank_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[ADDR_W-1 -: PAGE_W] == 8'h9F) |-> !bank_sel_n);

endmodule

// File: tb/bankmap_decode_top_tb_top.sv
`timescale 1ns/1ps
module bankmap_decode_top_tb_top;

    typedef struct {
        logic [6:0] sel;
        logic [2:0] hi;
        string      tag;
        logic [15:0] addr;
    } exp_t;

    logic        clk;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic        wr_stb;
    logic [3:0]  data_lo;
    logic        ram_a_n, ram_b_n, rom_n, ser_n, pio_usr_n, pio_sys_n, bank_sel_n;
    logic [2:0]  ram_hi;

    int   total;
    int   bad;
    bit   finished;
    logic [3:0] model_bank;
    exp_t q[$];

    bankmap_decode_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .wr_stb     (wr_stb),
        .data_lo    (data_lo),
        .ram_a_n    (ram_a_n),
        .ram_b_n    (ram_b_n),
        .rom_n      (rom_n),
        .ser_n      (ser_n),
        .pio_usr_n  (pio_usr_n),
        .pio_sys_n  (pio_sys_n),
        .bank_sel_n (bank_sel_n),
        .ram_hi     (ram_hi)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // Select bit order: {ram_a, ram_b, rom, serial, pio_user, pio_sys, bank_reg}, active low
    function automatic exp_t model(input logic [15:0] a, input logic [3:0] b, input string tag);
        exp_t e;
        logic [3:0] blk;
        logic [3:0] sub;
        blk = a[15:12];
        sub = a[11:8];
        e.sel = 7'b1111111;
        e.hi = 3'b000;
        e.tag = tag;
        e.addr = a;
        if (blk == 4'h0) begin
            e.sel[6] = 1'b0;
        end else if ((blk <= 4'h8) || (blk >= 4'hA && blk <= 4'hD && b != 4'h0)) begin
            if (b[3]) e.sel[5] = 1'b0;
            else      e.sel[6] = 1'b0;
            e.hi = b[2:0];
        end else if (blk >= 4'hA) begin
            e.sel[4] = 1'b0;
        end else begin
            case (sub)
                4'h1: e.sel[3] = 1'b0;
                4'h2: e.sel[2] = 1'b0;
                4'h3: e.sel[1] = 1'b0;
                4'hF: e.sel[0] = 1'b0;
                default: ;
            endcase
        end
        return e;
    endfunction

    task automatic access(input logic [15:0] a, input logic wr, input logic [3:0] d, input string tag);
        @(negedge clk);
        cpu_addr = a;
        wr_stb   = wr;
        data_lo  = d;
        q.push_back(model(a, model_bank, tag));
        if (wr && a[15:8] == 8'h9F) model_bank = d;
    endtask

    task automatic probe(input logic [15:0] a, input string tag);
        access(a, 1'b0, 4'h0, tag);
    endtask

    // Monitor: compares mid-cycle, after the driver has settled the inputs
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                logic [6:0] act;
                e = q.pop_front();
                act = {ram_a_n, ram_b_n, rom_n, ser_n, pio_usr_n, pio_sys_n, bank_sel_n};
                total++;
                if (act !== e.sel || ram_hi !== e.hi) begin
                    bad++;
                    $display("FAIL %s addr=%h sel=%b hi=%b expected sel=%b hi=%b",
                             e.tag, e.addr, act, ram_hi, e.sel, e.hi);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #1000000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        total = 0;
        bad = 0;
        finished = 1'b0;
        model_bank = 4'h0;
        rst_n = 1'b0;
        cpu_addr = 16'h0000;
        wr_stb = 1'b0;
        data_lo = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        probe(16'h1000, "R1 reset bank");

        // Bank 0 sweep
        probe(16'h0000, "R4 low window");
        probe(16'h0FFF, "R4 low window end");
        probe(16'h8FFF, "R5 ram window end");
        probe(16'hA000, "R6 swap bank0 rom");
        probe(16'hDFFF, "R6 swap bank0 rom end");
        probe(16'hE000, "R7 top rom");
        probe(16'hFFFF, "R7 top rom end");
        probe(16'h9000, "R10 hole 90");
        probe(16'h90FF, "R10 hole 90 end");
        probe(16'h9100, "R8 serial");
        probe(16'h9200, "R8 user pio");
        probe(16'h9300, "R8 system pio");
        probe(16'h9400, "R10 hole 94");
        probe(16'h9EFF, "R10 hole 9E");
        probe(16'h9F00, "R9 bank page read");

        // Load bank 8
        access(16'h9F00, 1'b1, 4'h8, "R9 bank page write");
        probe(16'h0000, "R4 low window bank8");
        probe(16'h1000, "R2 load bank8");
        probe(16'hD000, "R6 swap bank8");
        probe(16'hF000, "R7 top rom bank8");
        probe(16'h9100, "R8 serial bank8");
        probe(16'h9300, "R8 system pio bank8");
        probe(16'h9400, "R10 hole bank8");

        // Load bank 5 from another offset in the page
        access(16'h9F7A, 1'b1, 4'h5, "R9 bank page write offset");
        probe(16'h4F00, "R2 load bank5");
        probe(16'hA000, "R6 swap bank5");

        // Accesses that must not load
        access(16'h9F00, 1'b0, 4'hF, "R9 bank page read");
        probe(16'h1000, "R3 read keeps bank");
        access(16'h9E00, 1'b1, 4'hF, "R10 hole write");
        probe(16'h1000, "R3 hole write keeps bank");
        access(16'h9300, 1'b1, 4'h0, "R8 io write");
        probe(16'h2000, "R3 io write keeps bank");
        access(16'h1234, 1'b1, 4'hC, "R5 ram write");
        probe(16'hC000, "R3 ram write keeps bank");

        // Every bank value through both windows
        for (int b = 0; b < 16; b++) begin
            access(16'h9FFF, 1'b1, 4'(b), "R2 load sweep");
            probe(16'h2000, "R5 bank sweep");
            probe(16'hC000, "R6 bank sweep");
            probe(16'h0800, "R11 low window sweep");
        end

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R11 %0d results never compared", q.size());
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule